// File: doc/BRIEF.md
# Keyboard Controller A20 Gate Emulator

This block models the part of a PC/AT keyboard controller that software uses to open or close the A20 address gate and to request a CPU reset. A host issues I/O writes to a command port and a data port and reads back a status byte. A "write output port" command arms the controller, and the next data-port write loads an 8-bit output-port latch. Bit 1 of the latch drives the A20 gate. Bit 0 drives an active-low CPU reset request.

Every accepted write holds an input-buffer-full flag in the status byte for a programmable number of cycles. This models a slow controller that software must poll before it sends the next byte. A "pulse output port" command leaves the latch unchanged but holds the flag for a longer settle time. The latch can be read on the data port and is also brought out as a port, so that it can be saved and restored across suspend.

Top module: `kbc_a20_gate`

## Requirements
- R1: When reset is released, the output port holds 0xDD, `a20_gate` is 0, `cpu_reset_n` is 1 and the status byte reads 0x00.
- R2: A read of the command address returns the status byte on `io_rdata` one cycle after the read strobe. Bit 1 of that byte is the busy (input buffer full) flag and every other bit is 0.
- R3: Each accepted write to the command or data address sets busy for exactly BUSY_CYCLES cycles. A new write while busy restarts the count.
- R4: A command byte 0xD1 followed by a data-port write loads the data byte into the output port. `a20_gate` follows bit 1, so 0xDF opens the gate and 0xDD closes it.
- R5: A data-port write that does not directly follow an 0xD1 command leaves the output port unchanged.
- R6: Any command byte other than 0xD1 that arrives after 0xD1 cancels the armed state, and the next data write is then ignored.
- R7: Command 0xFF leaves the output port unchanged and sets busy for exactly SETTLE_CYCLES cycles.
- R8: Loading the output port with bit 0 equal to 0 drives `cpu_reset_n` low for exactly RST_PULSE cycles. Bit 0 of the latch then returns to 1 by itself.
- R9: A read of the data address returns the current output-port byte on `io_rdata` one cycle after the strobe, and `out_port` always shows the same byte.
- R10: Writes to any address other than the command and data addresses set no busy flag, do not arm the controller, and do not change the output port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| a20_gate | output | 1 | A20 gate enable (1 = address line 20 passes) |
| cpu_reset_n | output | 1 | Active-low CPU reset request |
| out_port | output | 8 | Current output-port latch, for save and restore |

## Verification
The bench builds the block with BUSY_CYCLES=20, SETTLE_CYCLES=45 and RST_PULSE=3. With these values the busy window, the longer settle window after 0xFF and the reset pulse can each be counted cycle by cycle from the ports. The two busy lengths differ, so a wrong reload value shows up as a count mismatch. The small pulse length lets the bench confirm that the latch's bit 0 restores itself within a short run.

// File: rtl/kbc_a20_pkg.sv
package kbc_a20_pkg;
  localparam logic [7:0] CMD_WRITE_OUTPORT = 8'hD1;
  localparam logic [7:0] CMD_PULSE_OUTPORT = 8'hFF;
  localparam logic [7:0] OUTPORT_INIT      = 8'hDD;
  localparam int         GATE_BIT          = 1;
  localparam int         RESET_BIT         = 0;
  localparam int         IBF_BIT           = 1;

  typedef enum logic {
    ARM_IDLE  = 1'b0,
    ARM_READY = 1'b1
  } arm_state_t;
endpackage

// File: rtl/kbc_io_decode.sv
module kbc_io_decode #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 16'h0064,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0060
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              cmd_wr,
  output logic              data_wr,
  output logic              status_rd,
  output logic              data_rd
);
  logic hit_cmd, hit_data;

  always_comb begin
    hit_cmd   = (io_addr == CMD_PORT);
    hit_data  = (io_addr == DATA_PORT);
    cmd_wr    = io_wr & hit_cmd;
    data_wr   = io_wr & hit_data;
    status_rd = io_rd & hit_cmd;
    data_rd   = io_rd & hit_data;
  end
endmodule

// File: rtl/kbc_busy_timer.sv
module kbc_busy_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy = (remain_q != '0);

  // R3
  busy_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> busy);

  // R3
  busy_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !busy) |=> !busy);
endmodule

// File: rtl/kbc_outport_latch.sv
module kbc_outport_latch
  import kbc_a20_pkg::*;
#(
  parameter int unsigned RST_PULSE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic [7:0] port_q
);
  localparam int unsigned RC_W = $clog2(RST_PULSE + 1);

  arm_state_t      arm_q;
  logic [RC_W-1:0] pulse_q;
  logic            load_en;

  assign load_en = data_wr && (arm_q == ARM_READY);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= ARM_IDLE;
      port_q  <= OUTPORT_INIT;
      pulse_q <= '0;
    end else begin
      if (pulse_q != '0) begin
        pulse_q <= pulse_q - 1'b1;
        if (pulse_q == RC_W'(1)) port_q[RESET_BIT] <= 1'b1;
      end
      if (cmd_wr) begin
        arm_q <= (wdata == CMD_WRITE_OUTPORT) ? ARM_READY : ARM_IDLE;
      end else if (load_en) begin
        arm_q   <= ARM_IDLE;
        port_q  <= wdata;
        pulse_q <= wdata[RESET_BIT] ? '0 : RC_W'(RST_PULSE);
      end
    end
  end

  // R4
  gate_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> port_q[GATE_BIT] == $past(wdata[GATE_BIT]));

  // R5
  unarmed_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && arm_q == ARM_IDLE && pulse_q == '0) |=> $stable(port_q));

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata != CMD_WRITE_OUTPORT) |=> arm_q == ARM_IDLE);

  // R7
  pulse_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata == CMD_PULSE_OUTPORT && pulse_q == '0) |=> $stable(port_q));

  // R8
  reset_source_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(port_q[RESET_BIT]) |-> $past(load_en && !wdata[RESET_BIT]));
endmodule

// File: rtl/kbc_a20_gate.sv
module kbc_a20_gate
  import kbc_a20_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] CMD_PORT      = 16'h0064,
  parameter logic [ADDR_W-1:0] DATA_PORT     = 16'h0060,
  parameter int unsigned       BUSY_CYCLES   = 2000,
  parameter int unsigned       SETTLE_CYCLES = 6000,
  parameter int unsigned       RST_PULSE     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              a20_gate,
  output logic              cpu_reset_n,
  output logic [7:0]        out_port
);
  localparam int unsigned MAX_WAIT = (BUSY_CYCLES > SETTLE_CYCLES) ? BUSY_CYCLES : SETTLE_CYCLES;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  logic             cmd_wr, data_wr, status_rd, data_rd;
  logic             busy;
  logic [CNT_W-1:0] wait_val;
  logic [7:0]       status_w;
  logic [7:0]       port_w;

  kbc_io_decode #(
    .ADDR_W    (ADDR_W),
    .CMD_PORT  (CMD_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_decode (
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .cmd_wr    (cmd_wr),
    .data_wr   (data_wr),
    .status_rd (status_rd),
    .data_rd   (data_rd)
  );

  assign wait_val = (cmd_wr && io_wdata == CMD_PULSE_OUTPORT) ?
                    CNT_W'(SETTLE_CYCLES) : CNT_W'(BUSY_CYCLES);

  kbc_busy_timer #(.CNT_W(CNT_W)) u_busy (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd_wr | data_wr),
    .load_val (wait_val),
    .busy     (busy)
  );

  kbc_outport_latch #(.RST_PULSE(RST_PULSE)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (cmd_wr),
    .data_wr (data_wr),
    .wdata   (io_wdata),
    .port_q  (port_w)
  );

  always_comb begin
    status_w          = '0;
    status_w[IBF_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
    end else if (status_rd) begin
      io_rdata <= status_w;
    end else if (data_rd) begin
      io_rdata <= port_w;
    end
  end

  assign out_port    = port_w;
  assign a20_gate    = port_w[GATE_BIT];
  assign cpu_reset_n = port_w[RESET_BIT];

  // R2
  status_format_chk: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (io_rdata[7:2] == 6'd0) && !io_rdata[0]);

  // R9
  data_read_chk: assert property (@(posedge clk) disable iff (rst)
    data_rd |=> io_rdata == $past(port_w));
endmodule

// File: tb/kbc_a20_gate_bench.sv
module kbc_a20_gate_bench;
  localparam int BUSY   = 20;
  localparam int SETTLE = 45;
  localparam int PULSE  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        a20_gate, cpu_reset_n;
  logic [7:0]  out_port;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  kbc_a20_gate #(
    .BUSY_CYCLES   (BUSY),
    .SETTLE_CYCLES (SETTLE),
    .RST_PULSE     (PULSE)
  ) u_kbc_a20_gate (
    .clk (clk), .rst (rst), .io_addr (io_addr), .io_wr (io_wr), .io_rd (io_rd),
    .io_wdata (io_wdata), .io_rdata (io_rdata), .a20_gate (a20_gate),
    .cpu_reset_n (cpu_reset_n), .out_port (out_port)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  // Called at the negedge right after a write; counts status samples with busy set.
  task automatic measure_busy(output int n, output int other);
    n = 0; other = 0;
    io_addr = 16'h0064; io_rd = 1'b1;
    for (int k = 0; k < 10000; k++) begin
      @(negedge clk);
      other = other | (io_rdata & 8'hFD);
      if (io_rdata[1]) n++;
      else if (n > 0 || k > 2) break;
    end
    io_rd = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (SETTLE + 5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 a20_gate", a20_gate, 0);
    check("R1 cpu_reset_n", cpu_reset_n, 1);
    rd(16'h0060, v);
    check("R1/R9 out port read", v, 8'hDD);
    rd(16'h0064, v);
    check("R1/R2 status", v, 8'h00);
  endtask

  task automatic t_open_gate();
    logic [7:0] v; int n, o;
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'hDF);
    measure_busy(n, o);
    check("R3 busy length", n, BUSY);
    check("R2 other status bits", o, 0);
    check("R4 a20 on", a20_gate, 1);
    rd(16'h0060, v);
    check("R9 read DF", v, 8'hDF);
    check("R9 out_port", out_port, 8'hDF);
  endtask

  task automatic t_close_gate();
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'hDD);
    check("R4 a20 off", a20_gate, 0);
  endtask

  task automatic t_unarmed();
    wr(16'h0060, 8'hDF);
    check("R5 unarmed data ignored", out_port, 8'hDD);
  endtask

  task automatic t_disarm();
    wr(16'h0064, 8'hD1);
    wr(16'h0064, 8'hAA);
    wr(16'h0060, 8'hDF);
    check("R6 disarmed data ignored", out_port, 8'hDD);
  endtask

  task automatic t_pulse();
    int n, o;
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'hDF);
    wait_idle();
    wr(16'h0064, 8'hFF);
    measure_busy(n, o);
    check("R7 settle length", n, SETTLE);
    check("R7 latch kept", out_port, 8'hDF);
    wr(16'h0060, 8'hDD);
    check("R7/R6 0xFF disarms", out_port, 8'hDF);
  endtask

  task automatic t_restart();
    int n, o;
    wait_idle();
    wr(16'h0064, 8'h20);
    repeat (5) @(negedge clk);
    wr(16'h0064, 8'h20);
    measure_busy(n, o);
    check("R3 restart", n, BUSY);
  endtask

  task automatic t_cpu_reset();
    int n;
    wr(16'h0064, 8'hD1);
    wr(16'h0060, 8'hDE);
    n = 0;
    while (!cpu_reset_n && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R8 reset pulse length", n, PULSE);
    check("R8 bit0 restored", out_port, 8'hDF);
  endtask

  task automatic t_other_addr();
    int n, o;
    wait_idle();
    wr(16'h0061, 8'hD1);
    measure_busy(n, o);
    check("R10 no busy", n, 0);
    wr(16'h0060, 8'hDD);
    check("R10 not armed", out_port, 8'hDF);
    wr(16'h0064, 8'hD1);
    wr(16'h0065, 8'hDD);
    check("R10 stray data ignored", out_port, 8'hDF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_open_gate();
    t_close_gate();
    t_unarmed();
    t_disarm();
    t_pulse();
    t_restart();
    t_cpu_reset();
    t_other_addr();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule